// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes for a host. A free-running 16x oversampling tick, produced elsewhere, paces a sampler. The sampler spots the falling edge of a start bit and confirms it at mid-bit. It then votes each following bit from three centre samples, checks an optional parity bit and reads the first stop bit. Each finished character goes into a two-entry buffer. Every entry keeps its own frame-error, overrun and parity-error flags beside the data byte. If both entries are full, one more finished character waits in a holding register. It moves into the buffer in the same cycle an entry is freed.

The host sees a read-only, two-location register window. Location 0 returns a status byte with the ready flag and the flags of the oldest unread character. Location 1 returns that character, and a read strobe there removes it from the buffer. The host must therefore sample status before it reads data. A ready output and a level interrupt report that unread data is present. Dropping the receive enable throws away everything buffered.

Top module: `uart_rx_buffered`

## Requirements
- R1: `rx_ready` is 1 exactly while the buffer holds at least one unread character, and 0 out of reset.
- R2: While `rx_en` is 0 the buffer, the holding register and the pending overrun are cleared, so `rx_ready` is 0 one cycle after `rx_en` falls. After re-enabling, reception starts clean.
- R3: `rx_irq` is a level that is 1 while `rx_ready` is 1 and `rx_ie` is 1. Error flags never raise it, and only emptying the buffer (or disabling interrupts) lowers it.
- R4: Reading location 0 (`host_addr`=0) returns bit 7 = ready, bit 2 = frame error, bit 1 = overrun and bit 0 = parity error, taken from the oldest unread entry. Bits 6..3 are 0, and all flags are 0 when the buffer is empty. Reading status changes no state.
- R5: A `host_rd` pulse at location 1 returns the oldest character and removes it. On an empty buffer the read returns the last character removed and changes nothing.
- R6: The frame-error flag is 1 when the first stop bit is voted 0. The sampler goes back to idle right after the first stop bit, so any later stop bit plays no part.
- R7: Overrun is recorded when the buffer is full, the holding register is occupied and a new start edge is seen. That new frame then replaces the held character. The flag is stored with the next character moved into the buffer, and the following move stores it as 0.
- R8: `par_mode[1]`=1 makes the frame carry a parity bit after data bit 7. `par_mode[0]`=1 selects odd parity and 0 selects even. The parity-error flag is 1 on a mismatch, and always 0 with `par_mode[1]`=0 (no parity bit expected then).
- R9: A frame starts on a high-to-low change of the synchronised line seen at an `os_tick`. A line that is high again at the 8th sample is taken as noise and dropped.
- R10: Data arrives LSB first. Each bit is the majority of samples 7, 8 and 9 of its 16, so a one-sample glitch does not change it.
- R11: Characters leave in arrival order. A character in the holding register enters the buffer in the same cycle a data read frees an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes all stored characters |
| rx_ie | input | 1 | Receive interrupt enable |
| par_mode | input | 2 | Bit 1 parity on, bit 0 odd (1) / even (0) |
| os_tick | input | 1 | 16x oversampling tick |
| rxd | input | 1 | Serial line, idle high |
| host_addr | input | 1 | 0 = status, 1 = data |
| host_rd | input | 1 | Read strobe; pops the buffer at location 1 |
| host_rdata | output | 8 | Read data for the selected location |
| rx_ready | output | 1 | Unread data present |
| rx_irq | output | 1 | Level receive interrupt |

## Verification
Characters with mixed bit patterns and no parity check LSB-first assembly. Even and odd parity frames, sent with both a correct and a wrong parity bit, separate the two senses of the check from a check that is always off. A bad stop bit queued ahead of a good frame shows that flags follow their own entry through the buffer. Three and then four back-to-back frames sent without reads separate a full buffer plus holding register, which loses nothing, from a true overrun, and show which character carries the flag. A short low pulse on an idle line and a one-sample glitch inside a data bit exercise start validation and the majority vote.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  localparam int RX_DW = 8;

  // status byte bit positions
  localparam int ST_RDY = 7;
  localparam int ST_FE  = 2;
  localparam int ST_OVR = 1;
  localparam int ST_PE  = 0;

  typedef struct packed {
    logic [RX_DW-1:0] data;
    logic             fe;
    logic             ovr;
    logic             pe;
  } rx_entry_t;

  typedef enum logic {SMP_IDLE, SMP_BUSY} smp_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // 1 when data plus parity bit do not match the chosen sense
  function automatic logic parity_bad(input logic [RX_DW-1:0] d, input logic p,
                                      input logic odd);
    return (^{d, p}) ^ odd;
  endfunction
endpackage

// File: rtl/uart_rx_sampler.sv
`timescale 1ns/1ps
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = RX_DW,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              os_tick,
  input  logic              line,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              start_seen,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_fe,
  output logic              frame_pe
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 3);
  localparam logic [CW-1:0] S_V0   = CW'(OSR/2 - 2);
  localparam logic [CW-1:0] S_V1   = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] S_V2   = CW'(OSR/2);
  localparam logic [CW-1:0] S_LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] B_LASTD = BW'(DATA_W);
  localparam logic [BW-1:0] B_PAR   = BW'(DATA_W + 1);

  smp_state_e        state;
  logic [CW-1:0]     scnt;
  logic [BW-1:0]     bidx;
  logic              line_last, v0, v1, par_q, odd_q, pbit_q;
  logic [DATA_W-1:0] shreg;
  logic              voted;
  logic [BW-1:0]     stop_idx;

  assign start_seen = enable && os_tick && (state == SMP_IDLE) && line_last && !line;
  assign voted      = vote3(v0, v1, line);
  assign stop_idx   = par_q ? BW'(DATA_W + 2) : BW'(DATA_W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SMP_IDLE; scnt <= '0; bidx <= '0; line_last <= 1'b1;
      v0 <= 1'b1; v1 <= 1'b1; par_q <= 1'b0; odd_q <= 1'b0; pbit_q <= 1'b0;
      shreg <= '0; frame_done <= 1'b0; frame_data <= '0;
      frame_fe <= 1'b0; frame_pe <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!enable) begin
        state     <= SMP_IDLE;
        line_last <= 1'b1;
      end else if (os_tick) begin
        line_last <= line;
        if (state == SMP_IDLE) begin
          if (start_seen) begin
            state <= SMP_BUSY;
            scnt  <= '0;
            bidx  <= '0;
            par_q <= par_en;
            odd_q <= par_odd;
          end
        end else begin
          scnt <= (scnt == S_LAST) ? '0 : scnt + 1'b1;
          if (scnt == S_LAST) bidx <= bidx + 1'b1;
          if (scnt == S_V0) v0 <= line;
          if (scnt == S_V1) v1 <= line;
          if (bidx == '0 && scnt == S_V1 && line) state <= SMP_IDLE;
          if (bidx != '0 && scnt == S_V2) begin
            if (bidx <= B_LASTD) begin
              shreg <= {voted, shreg[DATA_W-1:1]};
            end else if (par_q && bidx == B_PAR) begin
              pbit_q <= voted;
            end else if (bidx == stop_idx) begin
              frame_done <= 1'b1;
              frame_data <= shreg;
              frame_fe   <= !voted;
              frame_pe   <= par_q && parity_bad(shreg, pbit_q, odd_q);
              state      <= SMP_IDLE;
            end
          end
        end
      end
    end
  end

  // R8: no parity error is reported for a frame taken without parity
  p_par_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !par_q |-> !frame_pe);
  // R6: a finished frame leaves the sampler idle
  p_idle_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> state == SMP_IDLE);
  // R10: completions are single-cycle events
  p_single_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   P_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] C_FULL = CNTW'(DEPTH);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CNTW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == C_FULL);
  assign head  = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else if (flush) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push) wptr <= (wptr == P_LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == P_LAST) ? '0 : rptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 mem[i] <= '0;
        else if (!flush && push && wptr == AW'(i))  mem[i] <= push_entry;
      end
    end
  endgenerate

  // R11: never written beyond capacity
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush |-> !full || pop);
  // R5: removal only from a non-empty buffer
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/uart_rx_buffered.sv
`timescale 1ns/1ps
module uart_rx_buffered
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rx_ie,
  input  logic [1:0] par_mode,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       host_addr,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  output logic       rx_ready,
  output logic       rx_irq
);
  logic             rx_s1, rx_s2;
  logic             start_seen, frame_done, frame_fe, frame_pe;
  logic [RX_DW-1:0] frame_data;
  logic             pend_v, pend_fe, pend_pe, ovr_l;
  logic [RX_DW-1:0] pend_data, last_data;
  logic             f_empty, f_full, can_push, push, pop;
  rx_entry_t        head, push_entry;
  logic [7:0]       status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rx_s1 <= 1'b1; rx_s2 <= 1'b1; end
    else        begin rx_s1 <= rxd;  rx_s2 <= rx_s1; end
  end

  uart_rx_sampler #(.DATA_W(RX_DW), .OSR(OSR)) u_smp (
    .clk(clk), .rst_n(rst_n), .enable(rx_en), .os_tick(os_tick), .line(rx_s2),
    .par_en(par_mode[1]), .par_odd(par_mode[0]), .start_seen(start_seen),
    .frame_done(frame_done), .frame_data(frame_data), .frame_fe(frame_fe),
    .frame_pe(frame_pe));

  assign pop      = host_rd && host_addr && !f_empty;
  assign can_push = !f_full || pop;
  assign push     = (pend_v || frame_done) && can_push && rx_en;

  always_comb begin
    push_entry.ovr = ovr_l;
    if (pend_v) begin
      push_entry.data = pend_data; push_entry.fe = pend_fe; push_entry.pe = pend_pe;
    end else begin
      push_entry.data = frame_data; push_entry.fe = frame_fe; push_entry.pe = frame_pe;
    end
  end

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(push), .push_entry(push_entry),
    .pop(pop), .head(head), .empty(f_empty), .full(f_full));

  // holding register and overrun bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0; pend_fe <= 1'b0; pend_pe <= 1'b0; pend_data <= '0; ovr_l <= 1'b0;
    end else if (!rx_en) begin
      pend_v <= 1'b0; ovr_l <= 1'b0;
    end else begin
      if (pend_v && can_push) pend_v <= frame_done;
      else if (frame_done && !can_push) pend_v <= 1'b1;
      if (frame_done && (pend_v || !can_push)) begin
        pend_data <= frame_data; pend_fe <= frame_fe; pend_pe <= frame_pe;
      end
      if (start_seen && f_full && pend_v) ovr_l <= 1'b1;
      else if (push)                      ovr_l <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_data <= '0;
    else if (pop) last_data <= head.data;
  end

  always_comb begin
    status = '0;
    status[ST_RDY] = !f_empty;
    status[ST_FE]  = !f_empty && head.fe;
    status[ST_OVR] = !f_empty && head.ovr;
    status[ST_PE]  = !f_empty && head.pe;
  end

  assign host_rdata = host_addr ? (f_empty ? last_data : head.data) : status;
  assign rx_ready   = !f_empty;
  assign rx_irq     = rx_ie && rx_ready;

  // R2: disabling empties the buffer by the next cycle
  p_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_ready);
  // R7: overrun only follows a start edge with buffer and holder both occupied
  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_l) |-> $past(start_seen && f_full && pend_v));
  // R11: the holder is used only while the buffer is full
  p_hold_when_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> f_full);
  // R3: interrupt implies unread data
  p_irq_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !f_empty);
endmodule

// File: tb/uart_rx_buffered_bench.sv
`timescale 1ns/1ps
module uart_rx_buffered_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b1, rx_ie = 1'b1, os_tick = 1'b1, rxd = 1'b1;
  logic [1:0] par_mode = 2'b00;
  logic host_addr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic rx_ready, rx_irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_rx_buffered u_uart_rx_buffered (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_ie(rx_ie), .par_mode(par_mode),
    .os_tick(os_tick), .rxd(rxd), .host_addr(host_addr), .host_rd(host_rd),
    .host_rdata(host_rdata), .rx_ready(rx_ready), .rx_irq(rx_irq));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic ones_odd(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) n += d[i];
    return (n % 2) == 1;
  endfunction

  function automatic logic [7:0] stat(input bit rdy, input bit fe, input bit ov, input bit pe);
    return {rdy, 4'b0000, fe, ov, pe};
  endfunction

  task automatic drive_bit(input logic b, input bit glitch);
    for (int c = 0; c < 16; c++) begin
      rxd = (glitch && c == 8) ? ~b : b;
      @(negedge clk);
    end
  endtask

  // pmode: 0 no parity bit, 1 correct parity, 2 wrong parity
  task automatic send(input logic [7:0] d, input int pmode, input logic stop_b,
                      input int glitch_bit);
    logic p;
    p = par_mode[0] ? ~ones_odd(d) : ones_odd(d);
    drive_bit(1'b0, 0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], glitch_bit == i);
    if (pmode != 0) drive_bit(pmode == 1 ? p : ~p, 0);
    drive_bit(stop_b, 0);
    drive_bit(1'b1, 0);
  endtask

  task automatic peek_status(output logic [7:0] v);
    @(negedge clk); host_addr = 1'b0; #1 v = host_rdata;
  endtask

  task automatic read_data(output logic [7:0] v);
    @(negedge clk); host_addr = 1'b1; host_rd = 1'b1; #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0; host_addr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 reset ready", rx_ready, 0);
    check("R3 reset irq", rx_irq, 0);
    peek_status(v); check("R4 reset status", v, 0);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    send(8'hA5, 0, 1'b1, -1);
    check("R1 ready after frame", rx_ready, 1);
    check("R3 irq level", rx_irq, 1);
    peek_status(v); check("R4 clean status", v, stat(1, 0, 0, 0));
    read_data(v); check("R10 lsb-first data", v, 8'hA5);
    check("R1 ready cleared", rx_ready, 0);
    check("R3 irq cleared by read", rx_irq, 0);
    read_data(v); check("R5 empty read returns last", v, 8'hA5);
    check("R5 empty read no state change", rx_ready, 0);
    send(8'h3C, 0, 1'b1, -1);
    read_data(v); check("R10 second pattern", v, 8'h3C);
  endtask

  task automatic t_frame_err;
    logic [7:0] v;
    send(8'h55, 0, 1'b0, -1);
    peek_status(v); check("R6 bad stop sets fe", v, stat(1, 1, 0, 0));
    rx_ie = 1'b0; #1;
    check("R3 error does not raise irq", rx_irq, 0);
    rx_ie = 1'b1; #1;
    check("R3 irq follows ie", rx_irq, 1);
    peek_status(v); check("R4 status peek is non-destructive", v, stat(1, 1, 0, 0));
    read_data(v); check("R6 data with fe", v, 8'h55);
  endtask

  task automatic t_parity;
    logic [7:0] v;
    par_mode = 2'b10;
    send(8'h0F, 1, 1'b1, -1); peek_status(v); check("R8 even good", v, stat(1, 0, 0, 0));
    read_data(v); check("R8 even data", v, 8'h0F);
    send(8'h0F, 2, 1'b1, -1); peek_status(v); check("R8 even bad", v, stat(1, 0, 0, 1));
    read_data(v);
    par_mode = 2'b11;
    send(8'h01, 1, 1'b1, -1); peek_status(v); check("R8 odd good", v, stat(1, 0, 0, 0));
    read_data(v);
    send(8'h01, 2, 1'b1, -1); peek_status(v); check("R8 odd bad", v, stat(1, 0, 0, 1));
    read_data(v); check("R8 odd data", v, 8'h01);
    par_mode = 2'b01;
    send(8'h81, 0, 1'b1, -1); peek_status(v); check("R8 disabled pe 0", v, stat(1, 0, 0, 0));
    read_data(v); check("R8 disabled data", v, 8'h81);
    par_mode = 2'b00;
  endtask

  task automatic t_per_entry;
    logic [7:0] v;
    send(8'h11, 0, 1'b0, -1);
    send(8'h22, 0, 1'b1, -1);
    peek_status(v); check("R4 oldest flags first", v, stat(1, 1, 0, 0));
    read_data(v); check("R11 order first", v, 8'h11);
    peek_status(v); check("R4 second entry flags", v, stat(1, 0, 0, 0));
    read_data(v); check("R11 order second", v, 8'h22);
  endtask

  task automatic t_hold_and_overrun;
    logic [7:0] v;
    send(8'hC1, 0, 1'b1, -1); send(8'hC2, 0, 1'b1, -1); send(8'hC3, 0, 1'b1, -1);
    read_data(v); check("R11 hold first", v, 8'hC1);
    peek_status(v); check("R7 no overrun with holder only", v, stat(1, 0, 0, 0));
    read_data(v); check("R11 hold second", v, 8'hC2);
    read_data(v); check("R11 held char moved in", v, 8'hC3);
    check("R11 drained", rx_ready, 0);
    send(8'hD1, 0, 1'b1, -1); send(8'hD2, 0, 1'b1, -1);
    send(8'hD3, 0, 1'b1, -1); send(8'hD4, 0, 1'b1, -1);
    peek_status(v); check("R7 head before loss", v, stat(1, 0, 0, 0));
    read_data(v); check("R7 data 1", v, 8'hD1);
    read_data(v); check("R7 data 2", v, 8'hD2);
    peek_status(v); check("R7 overrun on moved char", v, stat(1, 0, 1, 0));
    read_data(v); check("R7 newest replaced held", v, 8'hD4);
    send(8'hD5, 0, 1'b1, -1);
    peek_status(v); check("R7 overrun cleared", v, stat(1, 0, 0, 0));
    read_data(v);
  endtask

  task automatic t_flush;
    logic [7:0] v;
    send(8'hE1, 0, 1'b1, -1); send(8'hE2, 0, 1'b1, -1);
    check("R2 ready before flush", rx_ready, 1);
    rx_en = 1'b0; @(negedge clk); @(negedge clk);
    check("R2 flushed", rx_ready, 0);
    check("R2 irq dropped", rx_irq, 0);
    rx_en = 1'b1; @(negedge clk);
    send(8'hE3, 0, 1'b1, -1);
    read_data(v); check("R2 fresh after enable", v, 8'hE3);
  endtask

  task automatic t_start_and_vote;
    logic [7:0] v;
    rxd = 1'b0; repeat (5) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
    check("R9 short pulse ignored", rx_ready, 0);
    send(8'h00, 0, 1'b1, 3);
    read_data(v); check("R10 glitch outvoted", v, 8'h00);
    send(8'hFF, 0, 1'b1, 6);
    read_data(v); check("R10 glitch outvoted high", v, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_basic;
    t_frame_err;
    t_parity;
    t_per_entry;
    t_hold_and_overrun;
    t_flush;
    t_start_and_vote;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule